// File: doc/BRIEF.md
# PMP Security Configuration Register File

This block holds the machine-level memory-protection security controls and the per-entry protection configuration bytes. It decides, on every configuration write, whether the write is applied. Three security bits are kept. `mml` selects the machine-mode lockdown interpretation of the lock bit. `mmwp` denies machine mode access when no rule matches. `rlb` is a bypass that lets locked rules be edited during boot.

Every write passes through a set of lock rules. The two mode bits can only be set. The bypass bit sticks at zero once a locked rule exists without it. A locked entry refuses edits unless the bypass is set. After lockdown, a write that would create a new rule executable by machine mode is dropped without any error. A synchronous protection reset clears the security bits and every lock bit in one cycle.

The outputs feed a separate permission checker. Address registers, address matching and the instruction decoder are outside this block. A parameter can tie the bypass bit to zero for a hardened build.

Top module: `pmp_seccfg_regs`

## Requirements
- R1: A security write (`wr_sel_sec`=1) with `wr_data[0]`=1 sets `sec_mml`. Once set, `sec_mml` stays 1 for any later write until a protection reset.
- R2: A security write with `wr_data[1]`=1 sets `sec_mmwp`. Once set, `sec_mmwp` stays 1 for any later write until a protection reset.
- R3: An entry whose stored bit 7 (lock) is 1 ignores all writes while `sec_rlb`=0. While `sec_rlb`=1, such an entry accepts writes.
- R4: When `sec_rlb`=0 and at least one entry has its lock bit set, a security write leaves `sec_rlb` at 0. Otherwise a security write loads `sec_rlb` from `wr_data[2]`.
- R5: When `sec_mml`=1 and `sec_rlb`=0, an entry write is discarded if the new value has bit 7=1 and bits 2:0 equal 001, 010, 011 or 101. The stored value is left unchanged. With `sec_rlb`=1 such a write is accepted.
- R6: An accepted entry write to index `wr_idx` stores `wr_data`, with bits 6:5 forced to zero. Entry i appears on `cfg_flat[8i+7:8i]`, and other entries are unchanged.
- R7: A `pmp_rst` cycle clears `sec_mml`, `sec_mmwp`, `sec_rlb` and bit 7 of every entry. It keeps the other entry bits and drops any write given in the same cycle.
- R8: With `HARD_RLB0`=1, `sec_rlb` reads 0 whatever is written.
- R9: After `rst_n` is asserted, all security bits and all entry bytes read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| pmp_rst | input | 1 | Synchronous protection reset |
| wr_en | input | 1 | Write strobe |
| wr_sel_sec | input | 1 | 1 targets the security register, 0 targets an entry |
| wr_idx | input | IDX_W | Entry index for entry writes |
| wr_data | input | 8 | Write data |
| sec_mml | output | 1 | Machine-mode lockdown bit |
| sec_mmwp | output | 1 | Machine-mode whitelist-policy bit |
| sec_rlb | output | 1 | Rule-lock bypass bit |
| cfg_flat | output | 8*NUM_ENTRIES | All entry configuration bytes |

## Verification
The properties assume that `pmp_rst` is the only path that can lower a sticky bit. They also assume that nothing other than a write or a protection reset changes an entry between two clock edges. The properties also assume that `rst_n` is held for at least one edge before checking starts. The stimulus respects these assumptions. It changes inputs only on falling clock edges, holds each write for exactly one rising edge, and drives `pmp_rst` only as single-cycle pulses while the power-on reset is released.

// File: rtl/pmp_seccfg_pkg.sv
package pmp_seccfg_pkg;
    localparam int CFG_W   = 8;
    localparam int L_BIT   = 7;
    localparam int RES_HI  = 6;
    localparam int RES_LO  = 5;
    localparam int SEC_MML_BIT  = 0;
    localparam int SEC_MMWP_BIT = 1;
    localparam int SEC_RLB_BIT  = 2;

    typedef logic [CFG_W-1:0] cfg_byte_t;

    typedef struct packed {
        logic mml;
        logic mmwp;
        logic rlb;
    } sec_bits_t;

    // New value would form a rule that machine mode may execute from
    function automatic logic is_m_exec(input cfg_byte_t v);
        logic [2:0] perm;
        perm = v[2:0];
        return v[L_BIT] && (perm == 3'b001 || perm == 3'b010 ||
                            perm == 3'b011 || perm == 3'b101);
    endfunction

    function automatic cfg_byte_t strip_reserved(input cfg_byte_t v);
        cfg_byte_t r;
        r = v;
        r[RES_HI:RES_LO] = '0;
        return r;
    endfunction
endpackage

// File: rtl/pmp_seccfg_lock_scan.sv
module pmp_seccfg_lock_scan #(
    parameter int NUM_ENTRIES = 16
) (
    input  logic [NUM_ENTRIES*pmp_seccfg_pkg::CFG_W-1:0] cfg_all,
    output logic                                        any_locked
);
    import pmp_seccfg_pkg::*;

    logic [NUM_ENTRIES-1:0] lock_vec;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_ENTRIES; gi++) begin : g_lock
            assign lock_vec[gi] = cfg_all[gi*CFG_W + L_BIT];
        end
    endgenerate

    assign any_locked = |lock_vec;
endmodule

// File: rtl/pmp_seccfg_sec_next.sv
module pmp_seccfg_sec_next #(
    parameter bit HARD_RLB0 = 1'b0
) (
    input  pmp_seccfg_pkg::sec_bits_t sec_q,
    input  logic                      pmp_rst,
    input  logic                      wr_sec,
    input  logic [2:0]                wr_bits,
    input  logic                      any_locked,
    output pmp_seccfg_pkg::sec_bits_t sec_d
);
    import pmp_seccfg_pkg::*;

    logic rlb_frozen;

    always_comb begin
        rlb_frozen = any_locked && !sec_q.rlb;
        sec_d      = sec_q;
        if (pmp_rst) begin
            sec_d = '0;
        end else if (wr_sec) begin
            sec_d.mml  = sec_q.mml  | wr_bits[SEC_MML_BIT];
            sec_d.mmwp = sec_q.mmwp | wr_bits[SEC_MMWP_BIT];
            if (!rlb_frozen) begin
                sec_d.rlb = wr_bits[SEC_RLB_BIT];
            end
        end
        if (HARD_RLB0) begin
            sec_d.rlb = 1'b0;
        end
    end
endmodule

// File: rtl/pmp_seccfg_entry_filter.sv
module pmp_seccfg_entry_filter (
    input  pmp_seccfg_pkg::cfg_byte_t cfg_q,
    input  logic                      hit,
    input  pmp_seccfg_pkg::cfg_byte_t wr_data,
    input  logic                      mml,
    input  logic                      rlb,
    input  logic                      pmp_rst,
    output pmp_seccfg_pkg::cfg_byte_t cfg_d
);
    import pmp_seccfg_pkg::*;

    cfg_byte_t clean;
    logic      locked_out;
    logic      exec_block;

    always_comb begin
        clean      = strip_reserved(wr_data);
        locked_out = cfg_q[L_BIT] && !rlb;
        exec_block = mml && !rlb && is_m_exec(clean);
        cfg_d      = cfg_q;
        if (pmp_rst) begin
            cfg_d[L_BIT] = 1'b0;
        end else if (hit && !locked_out && !exec_block) begin
            cfg_d = clean;
        end
    end
endmodule

// File: rtl/pmp_seccfg_regs.sv
module pmp_seccfg_regs #(
    parameter int NUM_ENTRIES = 16,
    parameter bit HARD_RLB0   = 1'b0,
    localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
    localparam int FLAT_W     = NUM_ENTRIES * pmp_seccfg_pkg::CFG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pmp_rst,
    input  logic              wr_en,
    input  logic              wr_sel_sec,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [7:0]        wr_data,
    output logic              sec_mml,
    output logic              sec_mmwp,
    output logic              sec_rlb,
    output logic [FLAT_W-1:0] cfg_flat
);
    import pmp_seccfg_pkg::*;

    typedef struct packed {
        sec_bits_t        sec;
        logic [FLAT_W-1:0] cfg;
    } state_t;

    state_t state_d, state_q;

    sec_bits_t         sec_nxt;
    logic [FLAT_W-1:0] cfg_nxt;
    logic              any_locked;
    logic              wr_sec;

    assign wr_sec = wr_en && wr_sel_sec;

    pmp_seccfg_lock_scan #(.NUM_ENTRIES(NUM_ENTRIES)) u_scan (
        .cfg_all    (state_q.cfg),
        .any_locked (any_locked)
    );

    pmp_seccfg_sec_next #(.HARD_RLB0(HARD_RLB0)) u_sec (
        .sec_q      (state_q.sec),
        .pmp_rst    (pmp_rst),
        .wr_sec     (wr_sec),
        .wr_bits    (wr_data[2:0]),
        .any_locked (any_locked),
        .sec_d      (sec_nxt)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NUM_ENTRIES; gi++) begin : g_ent
            logic hit;
            assign hit = wr_en && !wr_sel_sec && (wr_idx == IDX_W'(gi));
            pmp_seccfg_entry_filter u_filt (
                .cfg_q   (state_q.cfg[gi*CFG_W +: CFG_W]),
                .hit     (hit),
                .wr_data (wr_data),
                .mml     (state_q.sec.mml),
                .rlb     (state_q.sec.rlb),
                .pmp_rst (pmp_rst),
                .cfg_d   (cfg_nxt[gi*CFG_W +: CFG_W])
            );
        end
    endgenerate

    always_comb begin
        state_d     = state_q;
        state_d.sec = sec_nxt;
        state_d.cfg = cfg_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sec_mml  = state_q.sec.mml;
    assign sec_mmwp = state_q.sec.mmwp;
    assign sec_rlb  = state_q.sec.rlb;
    assign cfg_flat = state_q.cfg;
endmodule

// File: rtl/pmp_seccfg_chk.sv
module pmp_seccfg_chk #(
    parameter int NUM_ENTRIES = 16,
    parameter bit HARD_RLB0   = 1'b0
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          pmp_rst,
    input logic                          sec_mml,
    input logic                          sec_mmwp,
    input logic                          sec_rlb,
    input logic [NUM_ENTRIES*8-1:0]      cfg_flat
);
    import pmp_seccfg_pkg::*;

    logic [NUM_ENTRIES-1:0] locks;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_ENTRIES; gi++) begin : g_lk
            assign locks[gi] = cfg_flat[gi*8 + 7];
        end
    endgenerate

    // R1
    mml_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_mml && !pmp_rst) |=> sec_mml);

    // R2
    mmwp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_mmwp && !pmp_rst) |=> sec_mmwp);

    // R4
    rlb_stuck_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|locks) && !sec_rlb && !pmp_rst) |=> !sec_rlb);

    // R7
    prst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pmp_rst |=> (!sec_mml && !sec_mmwp && !sec_rlb && locks == '0));

    // R8
    hard_rlb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        HARD_RLB0 |-> !sec_rlb);

    generate
        for (gi = 0; gi < NUM_ENTRIES; gi++) begin : g_ent_chk
            // R3
            locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_flat[gi*8 + 7] && !sec_rlb && !pmp_rst) |=> $stable(cfg_flat[gi*8 +: 8]));

            // R5
            no_new_mexec_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (sec_mml && !sec_rlb && !pmp_rst && !is_m_exec(cfg_flat[gi*8 +: 8]))
                |=> !is_m_exec(cfg_flat[gi*8 +: 8]));

            // R6
            reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                cfg_flat[gi*8 + 6 -: 2] == 2'b00);
        end
    endgenerate
endmodule

bind pmp_seccfg_regs pmp_seccfg_chk #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .HARD_RLB0   (HARD_RLB0)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pmp_rst  (pmp_rst),
    .sec_mml  (sec_mml),
    .sec_mmwp (sec_mmwp),
    .sec_rlb  (sec_rlb),
    .cfg_flat (cfg_flat)
);

// File: tb/pmp_seccfg_regs_bench.sv
`timescale 1ns/1ps
module pmp_seccfg_regs_bench;
    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pmp_rst = 1'b0;
    logic         wr_en = 1'b0;
    logic         wr_sel_sec = 1'b0;
    logic [3:0]   wr_idx = '0;
    logic [7:0]   wr_data = '0;
    logic         sec_mml, sec_mmwp, sec_rlb;
    logic [N*8-1:0] cfg_flat;
    logic         h_mml, h_mmwp, h_rlb;
    logic [N*8-1:0] h_cfg;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pmp_seccfg_regs #(.NUM_ENTRIES(N)) u_pmp_seccfg_regs (
        .clk(clk), .rst_n(rst_n), .pmp_rst(pmp_rst), .wr_en(wr_en),
        .wr_sel_sec(wr_sel_sec), .wr_idx(wr_idx), .wr_data(wr_data),
        .sec_mml(sec_mml), .sec_mmwp(sec_mmwp), .sec_rlb(sec_rlb),
        .cfg_flat(cfg_flat)
    );

    pmp_seccfg_regs #(.NUM_ENTRIES(N), .HARD_RLB0(1'b1)) u_hard (
        .clk(clk), .rst_n(rst_n), .pmp_rst(pmp_rst), .wr_en(wr_en),
        .wr_sel_sec(wr_sel_sec), .wr_idx(wr_idx), .wr_data(wr_data),
        .sec_mml(h_mml), .sec_mmwp(h_mmwp), .sec_rlb(h_rlb),
        .cfg_flat(h_cfg)
    );

    typedef struct packed {
        logic       sel;
        logic [3:0] idx;
        logic [7:0] data;
        logic [2:0] exp_sec;   // {mml, mmwp, rlb}
        logic [7:0] exp_cfg;   // expected byte of entry idx
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'd0, 8'h1F, 3'b000, 8'h1F},  // R6 plain entry write
        '{1'b0, 4'd1, 8'hFF, 3'b000, 8'h9F},  // R6 reserved stripped, locks entry 1
        '{1'b1, 4'd1, 8'h04, 3'b000, 8'h9F},  // R4 rlb refused, lock present
        '{1'b0, 4'd1, 8'h00, 3'b000, 8'h9F},  // R3 locked entry ignores write
        '{1'b1, 4'd1, 8'h01, 3'b100, 8'h9F},  // R1 set mml
        '{1'b1, 4'd1, 8'h00, 3'b100, 8'h9F},  // R1 mml not cleared
        '{1'b0, 4'd2, 8'h8D, 3'b100, 8'h00},  // R5 L,rwx=101 dropped
        '{1'b0, 4'd2, 8'h89, 3'b100, 8'h00},  // R5 L,rwx=001 dropped
        '{1'b0, 4'd2, 8'h8C, 3'b100, 8'h8C},  // R5 L,rwx=100 accepted
        '{1'b0, 4'd3, 8'h0D, 3'b100, 8'h0D},  // R5 unlocked rwx=101 accepted
        '{1'b0, 4'd3, 8'h8F, 3'b100, 8'h8F},  // R5 L,rwx=111 accepted
        '{1'b1, 4'd3, 8'h02, 3'b110, 8'h8F},  // R2 set mmwp
        '{1'b1, 4'd3, 8'h00, 3'b110, 8'h8F}   // R2 mmwp not cleared
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ent(input logic [N*8-1:0] f, input int i);
        return f[i*8 +: 8];
    endfunction

    task automatic wr(input logic sel, input logic [3:0] idx, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel_sec = sel; wr_idx = idx; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic prst(input logic with_sec_write);
        @(negedge clk);
        pmp_rst = 1'b1;
        wr_en = with_sec_write; wr_sel_sec = 1'b1; wr_data = 8'h07;
        @(negedge clk);
        pmp_rst = 1'b0; wr_en = 1'b0;
    endtask

    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL R9 watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 sec bits", {sec_mml, sec_mmwp, sec_rlb}, 3'b000);
        check("R9 cfg all zero", {31'b0, cfg_flat == '0}, 1);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            wr(VECS[v].sel, VECS[v].idx, VECS[v].data);
            check($sformatf("R1-6 vec%0d sec", v), {sec_mml, sec_mmwp, sec_rlb}, VECS[v].exp_sec);
            check($sformatf("R3/R5/R6 vec%0d cfg", v), ent(cfg_flat, VECS[v].idx), VECS[v].exp_cfg);
        end
        check("R6 untouched entry 4", ent(cfg_flat, 4), 8'h00);

        // R7 protection reset: clears sec bits and locks, keeps the rest
        prst(1'b0);
        check("R7 sec cleared", {sec_mml, sec_mmwp, sec_rlb}, 3'b000);
        check("R7 entry1 lock cleared", ent(cfg_flat, 1), 8'h1F);
        check("R7 entry2 lock cleared", ent(cfg_flat, 2), 8'h0C);
        check("R7 entry3 lock cleared", ent(cfg_flat, 3), 8'h0F);
        check("R7 entry0 kept", ent(cfg_flat, 0), 8'h1F);

        // R4 bypass allowed with no locks
        wr(1'b1, 4'd0, 8'h04);
        check("R4 rlb set", sec_rlb, 1'b1);
        check("R8 hardened rlb stays 0", h_rlb, 1'b0);
        wr(1'b0, 4'd4, 8'h8D);
        check("R5 exec rule before lockdown", ent(cfg_flat, 4), 8'h8D);
        wr(1'b1, 4'd0, 8'h05);
        check("R4 rlb kept while set", {sec_mml, sec_rlb}, 2'b11);
        wr(1'b0, 4'd5, 8'h8B);
        check("R5 bypass admits exec rule", ent(cfg_flat, 5), 8'h8B);
        wr(1'b0, 4'd4, 8'h80);
        check("R3 bypass edits locked entry", ent(cfg_flat, 4), 8'h80);
        wr(1'b0, 4'd5, 8'h89);
        check("R8 hardened drops exec rule", ent(h_cfg, 5), 8'h00);
        wr(1'b1, 4'd0, 8'h01);
        check("R4 rlb cleared", sec_rlb, 1'b0);
        wr(1'b1, 4'd0, 8'h05);
        check("R4 rlb stuck at 0", sec_rlb, 1'b0);
        wr(1'b0, 4'd5, 8'h00);
        check("R3 locked entry refuses", ent(cfg_flat, 5), 8'h89);

        // R7 reset wins over same-cycle write
        prst(1'b1);
        check("R7 write dropped under reset", {sec_mml, sec_mmwp, sec_rlb}, 3'b000);
        check("R7 entry5 unlocked", ent(cfg_flat, 5), 8'h09);
        wr(1'b1, 4'd0, 8'h04);
        check("R8 hardened write ignored", h_rlb, 1'b0);
        check("R4 rlb after reset", sec_rlb, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule